// File: doc/BRIEF.md
# Mersenne Modulus Coefficient Folder

This block turns the output of a carry-free multiplier into a canonical residue. It reads a product one coefficient at a time. Each coefficient is a signed 32-bit value sitting at weight 2^(13·j). The block returns the product modulo N = 2^M − 1 as an ordinary M-bit binary number.

The block does not track the full 2·M-bit weight of each coefficient. It keeps a running bit position that steps by 13 and wraps at M, because 2^M ≡ 1 modulo N. It makes each coefficient unsigned by adding 2^31. It shifts the coefficient to its wrapped bit offset and adds the two 32-bit halves into two neighbouring word accumulators.

Once the last coefficient is in, a sequential carry pass visits one word per cycle. A constant supplied on a port then cancels the 2^31 offsets that were added. Two end-around folds and one conditional subtract of N give a result in [0, N−1].

Top module: `mersenne_fold_reduce`

## Requirements
- R1: After reset, done_o, busy_o and result_o are all 0.
- R2: A product's coefficients are its NCOEF accepted beats, where a beat is a cycle with coef_valid_i high while busy_o is low. They are taken in order, the first at j = 0, each read as two's-complement signed. With corr_i = C1 = (−2^31·Σ_j 2^(13j)) mod N, result_o equals (Σ_j p_j·2^(13j)) mod N.
- R3: The order of the beats sets the weights: beat j is weighted by 2^(13j), so swapping coefficients changes the result.
- R4: done_o is high for exactly one cycle. It rises WORDS+4 clock edges after the edge that accepted the last coefficient, where WORDS = ceil(M/32)+1 (43 edges for M = 1193). result_o holds its value until the next done_o.
- R5: busy_o is high from the edge after the last coefficient through the cycle in which done_o rises. While busy_o is high, coef_valid_i and coef_i have no effect on this result or on the next one.
- R6: result_o is canonical: a product that is a multiple of N gives 0, never the all-ones pattern.
- R7: The result is correct for coefficients at the extremes −2^31 and 2^31−1. It is also correct when a coefficient's wrapped bit position is a multiple of 32, so that the upper part of its split is zero. The wrapped position always stays below M.
- R8: corr_i is added once, before the folds, so corr_i = 0 gives (Σ_j p_j·2^(13j) − C1) mod N.
- R9: No word accumulator reaches its top bit for any legal input.
- R10: Idle cycles between coefficient beats are allowed and do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_valid_i | input | 1 | Coefficient beat present |
| coef_i | input | 32 | Signed coefficient, lowest weight first |
| corr_i | input | M | Offset-cancelling correction constant |
| busy_o | output | 1 | Reduction in progress; beats ignored |
| done_o | output | 1 | One-cycle pulse, result_o updated |
| result_o | output | M | Product mod 2^M − 1 in [0, N−1] |

## Verification
Each product's residue is due a fixed WORDS+4 edges after the beat that carried its last coefficient. Each scenario task counts falling edges from that beat, so it checks both the arrival cycle and the value, and then confirms that done_o has dropped one cycle later while result_o holds. busy_o is sampled on the falling edge that follows the final beat. Reference residues come from whole-integer signed arithmetic in the bench, not from any word splitting.

// File: rtl/mfr_pkg.sv
package mfr_pkg;
  typedef enum logic [2:0] {S_ACCUM, S_CARRY, S_ADDC, S_FOLD, S_FIX} phase_e;

  // Adding 2^31 to a signed 32-bit value is a flip of its sign bit.
  function automatic logic [31:0] unsign_coef(input logic [31:0] p);
    return p ^ 32'h8000_0000;
  endfunction

  // Shift into a 64-bit window: low half goes to word l, high half to l+1.
  // A zero offset leaves the high half zero without any 32-bit shift.
  function automatic logic [63:0] split_coef(input logic [31:0] pt, input logic [4:0] k);
    return {32'd0, pt} << k;
  endfunction
endpackage

// File: rtl/mfr_pos_track.sv
module mfr_pos_track #(
  parameter int M     = 1193,
  parameter int DIGIT = 13,
  parameter int PW    = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          clear_i,
  output logic [PW-1:0] pos_o
);
  logic [PW-1:0] pos_q, nxt;

  always_comb begin
    nxt = pos_q + PW'(DIGIT);
    if (nxt >= PW'(M)) nxt = nxt - PW'(M);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) pos_q <= '0;
    else if (step_i)       pos_q <= nxt;
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/mfr_acc_bank.sv
module mfr_acc_bank #(
  parameter int WORDS = 39,
  parameter int ACC_W = 41,
  parameter int LW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             add_i,
  input  logic [LW-1:0]    widx_i,
  input  logic [31:0]      lo_i,
  input  logic [31:0]      hi_i,
  input  logic [LW-1:0]    rd_idx_i,
  output logic [ACC_W-1:0] rd_o,
  output logic             top_any_o
);
  logic [WORDS*ACC_W-1:0] flat;
  logic [WORDS-1:0]       top_bits;
  logic [LW-1:0]          widx_up;

  assign widx_up = widx_i + LW'(1);

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [ACC_W-1:0] acc_q, add_v;
    always_comb begin
      add_v = '0;
      if (widx_i  == LW'(g)) add_v = add_v + ACC_W'(lo_i);
      if (widx_up == LW'(g)) add_v = add_v + ACC_W'(hi_i);
    end
    always_ff @(posedge clk) begin
      if (!rst_n || clear_i) acc_q <= '0;
      else if (add_i)        acc_q <= acc_q + add_v;
    end
    assign flat[g*ACC_W +: ACC_W] = acc_q;
    assign top_bits[g] = acc_q[ACC_W-1];
  end

  assign rd_o      = flat[int'(rd_idx_i)*ACC_W +: ACC_W];
  assign top_any_o = |top_bits;
endmodule

// File: rtl/mfr_wrap_fold.sv
module mfr_wrap_fold #(
  parameter int M  = 1193,
  parameter int XW = 1290
) (
  input  logic [XW-1:0] x_i,
  output logic [XW-1:0] y_o
);
  // 2^M is congruent to 1, so bits at or above M wrap back to bit 0.
  assign y_o = XW'(x_i[M-1:0]) + (x_i >> M);
endmodule

// File: rtl/mersenne_fold_reduce.sv
module mersenne_fold_reduce
  import mfr_pkg::*;
#(
  parameter int M     = 1193,
  parameter int NCOEF = 191,
  parameter int DIGIT = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         coef_valid_i,
  input  logic [31:0]  coef_i,
  input  logic [M-1:0] corr_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [M-1:0] result_o
);
  localparam int WORDS = (M + 31) / 32 + 1;
  localparam int LW    = $clog2(WORDS + 1);
  localparam int ACC_W = 32 + $clog2(2 * NCOEF);
  localparam int CYW   = ACC_W - 31;
  localparam int PW    = $clog2(M + DIGIT);
  localparam int CW    = $clog2(NCOEF + 1);
  localparam int XW    = 32 * WORDS + ACC_W + 1;
  localparam logic [M:0] NMOD = {1'b0, {M{1'b1}}};

  phase_e          phase_q;
  logic [CW-1:0]   cnt_q;
  logic [LW-1:0]   cidx_q;
  logic [CYW-1:0]  carry_q;
  logic            fstep_q;
  logic [XW-1:0]   x_q, x_fold;
  logic [M-1:0]    res_q;
  logic            done_q;
  logic [PW-1:0]   pos;
  logic [63:0]     split;
  logic [LW-1:0]   widx;
  logic [ACC_W-1:0] acc_rd;
  logic [ACC_W:0]  csum;
  logic [M:0]      fix_in;

  // Named events for the checker.
  logic take_evt, last_evt, fix_evt, acc_top_any, fold_hi_nz;

  assign take_evt   = coef_valid_i && (phase_q == S_ACCUM);
  assign last_evt   = take_evt && (cnt_q == CW'(NCOEF - 1));
  assign fix_evt    = (phase_q == S_FIX);
  assign split      = split_coef(unsign_coef(coef_i), pos[4:0]);
  assign widx       = LW'(pos >> 5);
  assign csum       = {1'b0, acc_rd} + (ACC_W + 1)'(carry_q);
  assign fix_in     = x_q[M:0];
  assign fold_hi_nz = |x_q[XW-1:M+1];

  mfr_pos_track #(.M(M), .DIGIT(DIGIT), .PW(PW)) u_pos (
    .clk(clk), .rst_n(rst_n), .step_i(take_evt), .clear_i(last_evt), .pos_o(pos)
  );

  mfr_acc_bank #(.WORDS(WORDS), .ACC_W(ACC_W), .LW(LW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear_i(fix_evt), .add_i(take_evt),
    .widx_i(widx), .lo_i(split[31:0]), .hi_i(split[63:32]),
    .rd_idx_i(cidx_q), .rd_o(acc_rd), .top_any_o(acc_top_any)
  );

  mfr_wrap_fold #(.M(M), .XW(XW)) u_fold (.x_i(x_q), .y_o(x_fold));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= S_ACCUM;
      cnt_q   <= '0;
      cidx_q  <= '0;
      carry_q <= '0;
      fstep_q <= 1'b0;
      x_q     <= '0;
      res_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        S_ACCUM: if (take_evt) begin
          if (last_evt) begin
            cnt_q   <= '0;
            cidx_q  <= '0;
            carry_q <= '0;
            phase_q <= S_CARRY;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        S_CARRY: begin
          x_q[32*int'(cidx_q) +: 32] <= csum[31:0];
          carry_q <= csum[ACC_W:32];
          cidx_q  <= cidx_q + LW'(1);
          if (cidx_q == LW'(WORDS - 1)) phase_q <= S_ADDC;
        end
        S_ADDC: begin
          x_q     <= x_q + (XW'(carry_q) << (32 * WORDS)) + XW'(corr_i);
          fstep_q <= 1'b0;
          phase_q <= S_FOLD;
        end
        S_FOLD: begin
          x_q     <= x_fold;
          fstep_q <= 1'b1;
          if (fstep_q) phase_q <= S_FIX;
        end
        S_FIX: begin
          res_q   <= (fix_in >= NMOD) ? M'(fix_in - NMOD) : fix_in[M-1:0];
          done_q  <= 1'b1;
          x_q     <= '0;
          phase_q <= S_ACCUM;
        end
        default: phase_q <= S_ACCUM;
      endcase
    end
  end

  assign busy_o   = (phase_q != S_ACCUM);
  assign done_o   = done_q;
  assign result_o = res_q;
endmodule

// File: rtl/mfr_checker.sv
module mfr_checker #(
  parameter int M     = 1193,
  parameter int NCOEF = 191,
  parameter int PW    = 11,
  parameter int CW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done_o,
  input logic          busy_o,
  input logic [M-1:0]  result_o,
  input logic [PW-1:0] pos,
  input logic [CW-1:0] cnt_q,
  input logic          fix_evt,
  input logic          acc_top_any,
  input logic          fold_hi_nz
);
  a_r7_pos_below_m: assert property (@(posedge clk) disable iff (!rst_n)
    pos < PW'(M));
  a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r4_done_follows_fix: assert property (@(posedge clk) disable iff (!rst_n)
    fix_evt |=> done_o);
  a_r6_never_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (result_o != {M{1'b1}}));
  a_r6_fold_fits: assert property (@(posedge clk) disable iff (!rst_n)
    fix_evt |-> !fold_hi_nz);
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_top_any);
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(NCOEF));
  a_r5_busy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(cnt_q) && $stable(pos)));
endmodule

bind mersenne_fold_reduce mfr_checker #(.M(M), .NCOEF(NCOEF), .PW(PW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .done_o(done_o), .busy_o(busy_o), .result_o(result_o),
  .pos(pos), .cnt_q(cnt_q), .fix_evt(fix_evt), .acc_top_any(acc_top_any),
  .fold_hi_nz(fold_hi_nz)
);

// File: tb/mersenne_fold_reduce_bench.sv
`timescale 1ns/1ps
module mersenne_fold_reduce_bench;
  localparam int M     = 1193;
  localparam int NCOEF = 191;
  localparam int DIGIT = 13;
  localparam int WORDS = (M + 31) / 32 + 1;
  localparam int BW    = DIGIT * NCOEF + 80;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0;
  logic [31:0]  coef = '0;
  logic [M-1:0] corr_i = '0;
  logic         busy_o, done_o;
  logic [M-1:0] result_o;

  int nchk = 0, nfail = 0;
  bit ended = 0;
  int coefs [NCOEF];
  logic [BW-1:0] nbig, c1big;

  always #4 clk = ~clk;

  mersenne_fold_reduce #(.M(M), .NCOEF(NCOEF), .DIGIT(DIGIT)) u_mersenne_fold_reduce (
    .clk(clk), .rst_n(rst_n), .coef_valid_i(valid), .coef_i(coef), .corr_i(corr_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  task automatic chk(input string req, input logic [M-1:0] got, input logic [M-1:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // Whole-integer reference: signed sum of weighted coefficients, then mod N.
  function automatic logic [M-1:0] ref_result(input bit with_corr);
    logic signed [BW-1:0] s, t;
    logic [BW-1:0] m, r;
    s = '0;
    for (int j = 0; j < NCOEF; j++) begin
      t = coefs[j];
      s = s + (t <<< (DIGIT * j));
    end
    if (s < 0) begin
      m = BW'(-s) % nbig;
      r = (m == '0) ? '0 : nbig - m;
    end else begin
      r = BW'(s) % nbig;
    end
    if (!with_corr) r = (r + nbig - c1big) % nbig;
    return r[M-1:0];
  endfunction

  task automatic run_product(input string req, input bit gaps, input bit noise,
                             input bit with_corr);
    logic [M-1:0] exp_v;
    int lat;
    exp_v  = ref_result(with_corr);
    corr_i = with_corr ? c1big[M-1:0] : '0;
    for (int j = 0; j < NCOEF; j++) begin
      if (gaps && (j % 3 == 1)) begin
        valid = 1'b0; coef = $urandom; @(negedge clk);
      end
      valid = 1'b1; coef = coefs[j]; @(negedge clk);
    end
    valid = noise;
    chk({req, " R5 busy after last beat"}, M'(busy_o), M'(1));
    lat = 0;
    while (!done_o && lat < 200) begin
      if (noise) coef = $urandom;
      @(negedge clk);
      lat++;
    end
    valid = 1'b0;
    chk({req, " value"}, result_o, exp_v);
    chk({req, " R4 latency"}, M'(lat), M'(WORDS + 4));
    @(negedge clk);
    chk({req, " R4 pulse drop"}, M'(done_o), M'(0));
    chk({req, " R4 result held"}, result_o, exp_v);
  endtask

  task automatic t_reset();
    chk("R1 done at reset", M'(done_o), M'(0));
    chk("R1 busy at reset", M'(busy_o), M'(0));
    chk("R1 result at reset", result_o, '0);
  endtask

  task automatic t_random(input string req, input bit gaps, input bit noise, input bit with_corr);
    for (int j = 0; j < NCOEF; j++) coefs[j] = int'($urandom);
    run_product(req, gaps, noise, with_corr);
  endtask

  task automatic t_swap();
    // R3: reverse the previous vector so weights move.
    int tmp;
    for (int j = 0; j < NCOEF / 2; j++) begin
      tmp = coefs[j]; coefs[j] = coefs[NCOEF-1-j]; coefs[NCOEF-1-j] = tmp;
    end
    run_product("R3 reversed order", 0, 0, 1);
  endtask

  task automatic t_extremes();
    for (int j = 0; j < NCOEF; j++) coefs[j] = 32'sh8000_0000;
    run_product("R7 all most-negative", 0, 0, 1);
    for (int j = 0; j < NCOEF; j++) coefs[j] = 32'sh7fff_ffff;
    run_product("R7 all most-positive", 0, 0, 1);
    for (int j = 0; j < NCOEF; j++)
      coefs[j] = (((DIGIT * j) % M) % 32 == 0) ? 32'sh7fff_ffff : -1;
    run_product("R7 word-aligned positions", 0, 0, 1);
  endtask

  task automatic t_multiple_of_n();
    // R6: digits of N itself, so the residue must be 0.
    logic [BW-1:0] d;
    for (int j = 0; j < NCOEF; j++) begin
      d = (nbig >> (DIGIT * j)) & BW'(32'h1fff);
      coefs[j] = int'(d[31:0]);
    end
    run_product("R6 multiple of N", 0, 0, 1);
    chk("R6 zero not all-ones", result_o, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    nbig  = (BW'(1) << M) - BW'(1);
    c1big = '0;
    for (int j = 0; j < NCOEF; j++) c1big = c1big + (BW'(1) << (31 + DIGIT * j));
    c1big = (nbig - (c1big % nbig)) % nbig;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_random("R2 random", 0, 0, 1);
    t_swap();
    t_random("R10 idle gaps", 1, 0, 1);
    t_extremes();
    t_multiple_of_n();
    t_random("R8 zero correction", 0, 0, 0);
    t_random("R5 beats while busy", 0, 1, 1);
    t_random("R5 follow-up product", 0, 0, 1);
    t_random("R9 random load", 1, 0, 1);
    finish_run();
  end
endmodule